// File: doc/BRIEF.md
# Nibble-Wide Display RAM Host Port

This block gives a host processor access to a nibble-organised store through a narrow 4-bit data path and four control strobes. The host first places the block in address mode and delivers a 12-bit nibble address as three nibbles, most significant first. It then switches to data mode, and every write or read strobe moves one nibble and steps an internal pointer. A whole display image can therefore be streamed without re-addressing.

The bottom 2560 nibble addresses hold RAM. The three addresses directly above it hold control registers, whose fields are brought out as configuration outputs for the analog supply circuitry. All higher addresses are unmapped. The pad-side tri-state buffer sits outside the block, so the bidirectional bus appears here as a separate input, output and output-enable.

Top module: `nibble_ram_port`

## Requirements
- R1: After a synchronous reset the configuration outputs read as follows: external-resistor select 0, resistor ratio 2, supply configuration 0 and regulator trim 0. These are the register values 0010, 0000 and 0000 at 2560, 2561 and 2562. The output-enable is low.
- R2: While enabled (`en_n` low) with `sel_data` low, each rising edge of `wr_stb` loads one nibble of the pointer from `dq_i`. The first edge loads bits 11:8, the second loads bits 7:4 and the third loads bits 3:0.
- R3: While enabled with `sel_data` high, a rising edge of `wr_stb` stores `dq_i` at the pointer and then adds one to the pointer.
- R4: While enabled with `sel_data` high and `rd_stb` high, `dq_oe` is high and `dq_o` shows the nibble at the pointer. When `rd_stb` falls the pointer advances by one.
- R5: While `en_n` is high, strobes neither write, drive the bus nor move the pointer.
- R6: Leaving address mode resets the nibble slot. The next address nibble always loads bits 11:8, even if an earlier load stopped part way.
- R7: The pointer wraps from 4095 to 0.
- R8: A write to 2560 sets the external-resistor select from bit 3 and the ratio from bits 2:0. A write to 2561 sets trim bits 3:0. A write to 2562 sets the supply configuration from bits 3:2 and trim bits 5:4 from bits 1:0. Reads at these addresses return the stored nibbles.
- R9: Writes to addresses 2563 to 4095 change nothing, and reads there return 0.
- R10: `dq_oe` is low whenever `rd_stb` is low, and also in address mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low access enable |
| sel_data | input | 1 | 0 = address mode, 1 = data mode |
| wr_stb | input | 1 | Write strobe, acts on rising edge |
| rd_stb | input | 1 | Read strobe, drives while high |
| dq_i | input | 4 | Nibble from host |
| dq_o | output | 4 | Nibble to host |
| dq_oe | output | 1 | Output-enable for the pad buffer |
| cfg_ext_res | output | 1 | External-resistor select |
| cfg_ratio | output | 3 | Resistor-ratio code |
| cfg_supply | output | 2 | Supply configuration |
| cfg_trim | output | 6 | Regulator trim code |

## Verification
Several properties are checked on every cycle: the pointer holds while the block is disabled, it wraps to zero after 4095, the nibble slot restarts after address mode is left, the bus is driven only during an enabled data-mode read, and unmapped writes leave the registers alone. Only the bench scenarios can show that data actually lands at the right address. They also show that address nibbles go to the right bit positions and that the register fields reach the configuration outputs. A full write and read-back sweep of the RAM, loads that stop part way, and streams across the register and wrap boundaries cover these cases.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
    localparam int ADDR_W   = 12;
    localparam int NIB_W    = 4;
    localparam int NUM_REGS = 3;
    localparam int SLOT_W   = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic       ext_res;
        logic [2:0] ratio;
        logic [1:0] supply;
        logic [5:0] trim;
    } cfg_t;

    function automatic nib_t reg_default(int unsigned idx);
        return (idx == 0) ? 4'b0010 : 4'b0000;
    endfunction

    function automatic slot_t next_slot(slot_t s);
        return (s == 2'd2) ? 2'd0 : s + 2'd1;
    endfunction

    // High nibble first, low nibble last.
    function automatic addr_t load_slot(addr_t a, slot_t s, nib_t n);
        addr_t r;
        r = a;
        case (s)
            2'd0:    r[11:8] = n;
            2'd1:    r[7:4]  = n;
            default: r[3:0]  = n;
        endcase
        return r;
    endfunction

    function automatic cfg_t unpack_regs(nib_t r0, nib_t r1, nib_t r2);
        cfg_t c;
        c.ext_res = r0[3];
        c.ratio   = r0[2:0];
        c.supply  = r2[3:2];
        c.trim    = {r2[1:0], r1};
        return c;
    endfunction
endpackage

// File: rtl/nrp_seq.sv
module nrp_seq
    import nrp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_n,
    input  logic  sel_data,
    input  logic  wr_stb,
    input  logic  rd_stb,
    input  nib_t  dq_i,
    output addr_t ptr,
    output logic  data_wr,
    output logic  rd_on
);
    logic  wr_q, rd_q;
    slot_t slot;
    logic  wr_rise, rd_fall, addr_mode, data_mode;

    always_comb begin
        wr_rise   = wr_stb & ~wr_q;
        rd_fall   = ~rd_stb & rd_q;
        addr_mode = ~en_n & ~sel_data;
        data_mode = ~en_n & sel_data;
        data_wr   = data_mode & wr_rise;
        rd_on     = data_mode & rd_stb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_stb;
            rd_q <= rd_stb;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !addr_mode)
            slot <= '0;
        else if (wr_rise)
            slot <= next_slot(slot);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (addr_mode && wr_rise)
            ptr <= load_slot(ptr, slot, dq_i);
        else if (data_mode && (wr_rise || rd_fall))
            ptr <= ptr + addr_t'(1);
    end

    a_r5_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        en_n |=> $stable(ptr));
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (data_mode && wr_rise && ptr == addr_t'(4095)) |=> ptr == '0);
    a_r6_slot_restart: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_data) && !en_n && !sel_data) |-> slot == '0);
    a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
        slot != 2'd3);
endmodule

// File: rtl/nrp_store.sv
module nrp_store
    import nrp_pkg::*;
#(
    parameter int DEPTH = 2560
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t ptr,
    input  logic  we,
    input  nib_t  wd,
    output nib_t  rdata,
    output logic [NUM_REGS-1:0][NIB_W-1:0] regs_q
);
    localparam addr_t REG_BASE = addr_t'(DEPTH);

    nib_t  mem [DEPTH];
    addr_t rel;
    logic  in_mem, in_reg;
    nib_t  reg_rd;

    always_comb begin
        rel    = ptr - REG_BASE;
        in_mem = ptr < REG_BASE;
        in_reg = !in_mem && (rel < addr_t'(NUM_REGS));
    end

    always_ff @(posedge clk) begin
        if (we && in_mem)
            mem[ptr] <= wd;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= reg_default(g);
            else if (we && in_reg && rel == addr_t'(g))
                regs_q[g] <= wd;
        end
    end

    always_comb begin
        reg_rd = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (rel == addr_t'(k)) reg_rd = regs_q[k];
        if (in_mem)      rdata = mem[ptr];
        else if (in_reg) rdata = reg_rd;
        else             rdata = '0;
    end

    a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && !in_mem && !in_reg) |=> $stable(regs_q));
endmodule

// File: rtl/nibble_ram_port.sv
module nibble_ram_port
    import nrp_pkg::*;
#(
    parameter int MEM_NIBBLES = 2560
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_n,
    input  logic       sel_data,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [3:0] dq_i,
    output logic [3:0] dq_o,
    output logic       dq_oe,
    output logic       cfg_ext_res,
    output logic [2:0] cfg_ratio,
    output logic [1:0] cfg_supply,
    output logic [5:0] cfg_trim
);
    addr_t ptr;
    logic  data_wr, rd_on;
    nib_t  rdata;
    logic [NUM_REGS-1:0][NIB_W-1:0] regs;
    cfg_t  cfg;

    nrp_seq u_seq (
        .clk(clk), .rst(rst), .en_n(en_n), .sel_data(sel_data),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .dq_i(dq_i),
        .ptr(ptr), .data_wr(data_wr), .rd_on(rd_on)
    );

    nrp_store #(.DEPTH(MEM_NIBBLES)) u_store (
        .clk(clk), .rst(rst), .ptr(ptr), .we(data_wr), .wd(dq_i),
        .rdata(rdata), .regs_q(regs)
    );

    always_comb begin
        cfg         = unpack_regs(regs[0], regs[1], regs[2]);
        cfg_ext_res = cfg.ext_res;
        cfg_ratio   = cfg.ratio;
        cfg_supply  = cfg.supply;
        cfg_trim    = cfg.trim;
        dq_o        = rdata;
        dq_oe       = rd_on;
    end

    a_r4_drive_only_on_read: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (rd_stb && !en_n && sel_data));
    a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> !dq_oe);
endmodule

// File: tb/test_nibble_ram_port.sv
module test_nibble_ram_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_n = 1'b1, sel_data = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [3:0] dq_i = '0;
    logic [3:0] dq_o;
    logic       dq_oe, cfg_ext_res;
    logic [2:0] cfg_ratio;
    logic [1:0] cfg_supply;
    logic [5:0] cfg_trim;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    nibble_ram_port i_nibble_ram_port (
        .clk(clk), .rst(rst), .en_n(en_n), .sel_data(sel_data),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe(dq_oe), .cfg_ext_res(cfg_ext_res), .cfg_ratio(cfg_ratio),
        .cfg_supply(cfg_supply), .cfg_trim(cfg_trim)
    );

    function automatic logic [3:0] pat(int a);
        return 4'((a * 7 + (a >> 4) + 3) & 15);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_nib(logic [3:0] d);
        dq_i = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_nib(string tag, logic [3:0] exp);
        rd_stb = 1'b1;
        #1;
        chk({tag, " oe"}, int'(dq_oe), 1);
        chk({tag, " data"}, int'(dq_o), int'(exp));
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_addr(int a);
        en_n = 1'b0; sel_data = 1'b0;
        @(negedge clk);
        wr_nib(4'(a >> 8));
        wr_nib(4'(a >> 4));
        wr_nib(4'(a));
        sel_data = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset defaults
        chk("R1 ext_res", int'(cfg_ext_res), 0);
        chk("R1 ratio", int'(cfg_ratio), 2);
        chk("R1 supply", int'(cfg_supply), 0);
        chk("R1 trim", int'(cfg_trim), 0);
        chk("R1 oe", int'(dq_oe), 0);

        // R2 R3 R4 exhaustive RAM sweep
        set_addr(0);
        for (int a = 0; a < 2560; a++) wr_nib(pat(a));
        set_addr(0);
        for (int a = 0; a < 2560; a++) rd_nib("R3 R4 sweep", pat(a));
        chk("R10 idle oe", int'(dq_oe), 0);

        // R2 address nibble order
        set_addr(12'h4A7);
        rd_nib("R2 order", pat(12'h4A7));

        // R8 registers, then R9 unmapped
        set_addr(2560);
        wr_nib(4'hB); wr_nib(4'h5); wr_nib(4'hE);
        chk("R8 ext_res", int'(cfg_ext_res), 1);
        chk("R8 ratio", int'(cfg_ratio), 3);
        chk("R8 supply", int'(cfg_supply), 3);
        chk("R8 trim", int'(cfg_trim), 6'h25);
        wr_nib(4'h9); wr_nib(4'h6);
        chk("R9 cfg unchanged", int'({cfg_ext_res, cfg_ratio, cfg_supply, cfg_trim}),
            int'({1'b1, 3'd3, 2'd3, 6'h25}));
        set_addr(2560);
        rd_nib("R8 rd 2560", 4'hB);
        rd_nib("R8 rd 2561", 4'h5);
        rd_nib("R8 rd 2562", 4'hE);
        rd_nib("R9 rd 2563", 4'h0);
        rd_nib("R9 rd 2564", 4'h0);
        set_addr(2559);
        rd_nib("R9 last ram", pat(2559));

        // R7 wrap on write and read
        set_addr(4095);
        wr_nib(4'h9);
        wr_nib(4'hC);
        set_addr(4095);
        rd_nib("R7 R9 rd 4095", 4'h0);
        rd_nib("R7 wrap rd 0", 4'hC);
        rd_nib("R7 then 1", pat(1));

        // R5 disabled strobes
        set_addr(100);
        en_n = 1'b1;
        wr_nib(4'h0);
        rd_stb = 1'b1;
        #1 chk("R5 oe while disabled", int'(dq_oe), 0);
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
        en_n = 1'b0;
        @(negedge clk);
        rd_nib("R5 no write no step", pat(100));

        // R10 no drive in address mode
        sel_data = 1'b0;
        @(negedge clk);
        rd_stb = 1'b1;
        #1 chk("R10 oe addr mode", int'(dq_oe), 0);
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);

        // R6 interrupted address load
        wr_nib(4'hF); wr_nib(4'h7);
        sel_data = 1'b1; @(negedge clk);
        sel_data = 1'b0; @(negedge clk);
        wr_nib(4'h0); wr_nib(4'h0); wr_nib(4'h5);
        sel_data = 1'b1; @(negedge clk);
        rd_nib("R6 restart", pat(5));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule